// File: doc/BRIEF.md
# Exception Priority Mask and Control Register Block

This block holds the special-purpose registers a processor core uses to gate exception activation and to pick its stack and Thread privilege level. It keeps a base-priority threshold, a single fault-mask bit and a two-bit control register. From these and the priority of the most urgent pending exception it produces, in the same cycle, a flag that says whether that exception may activate now.

The core reports its current mode (Thread or Handler) and the register writes that software requests. It also strobes exception entry, and exception return together with the returning exception number and a one-bit stack code. The block applies the writes only from privileged state. It updates the stack selection and the fault mask on entry and return, and exposes the active stack selection and the Thread privilege level. A combinational read port returns any register as a 32-bit word with every unused bit at zero.

Top module: `exm_mask_ctrl`

## Requirements
- R1: After reset all three registers read as zero, `sp_sel` and `thread_unpriv` are 0, and any valid pending exception is permitted.
- R2: A write with `wr_sel`=0 stores `wr_data[7:4]` as the base-priority threshold. A read with `rd_sel`=0 returns it in bits 7:4 with all other bits zero. A read with `rd_sel`=3 returns zero.
- R3: With a threshold of zero, every valid pending exception is permitted. With a nonzero threshold, a configurable exception is blocked when its priority value is greater than or equal to the threshold and permitted when it is smaller.
- R4: A write with `wr_sel`=1 stores `wr_data[0]` as the fault mask, which reads back in bit 0. While it is set, every configurable exception is blocked. A pending exception flagged `pend_fixed`=1 is permitted regardless of the masks. `act_ok` is 0 whenever `pend_valid` is 0.
- R5: An exception return whose `ret_excnum` is not 2 clears the fault mask. A return with `ret_excnum`=2 leaves it unchanged.
- R6: A write with `wr_sel`=2 stores `wr_data[0]` as the Thread privilege bit (1 = unprivileged, driven on `thread_unpriv`). In Thread mode it also stores `wr_data[1]` as the stack select (1 = process stack). In Handler mode the stack-select bit of the write is ignored. In Handler mode that bit also reads as zero (control read bit 1) and `sp_sel` is 0.
- R7: Exception entry clears the stack select. An exception return with `ret_thread`=1 loads it from `ret_psp`. A return with `ret_thread`=0 clears it.
- R8: A write in Thread mode while the privilege bit is 1 is dropped and changes no register.
- R9: A write in the same cycle as an entry or return strobe is dropped. The strobe's own update still happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| handler_mode | input | 1 | 1 = Handler mode, 0 = Thread mode |
| wr_en | input | 1 | Register write request |
| wr_sel | input | 2 | Write target: 0 threshold, 1 fault mask, 2 control |
| wr_data | input | 32 | Write data word |
| rd_sel | input | 2 | Read target: 0 threshold, 1 fault mask, 2 control, 3 none |
| rd_data | output | 32 | Read data word |
| exc_entry | input | 1 | Exception entry strobe |
| exc_return | input | 1 | Exception return strobe |
| ret_excnum | input | 9 | Number of the exception being returned from |
| ret_thread | input | 1 | Return goes back to Thread mode |
| ret_psp | input | 1 | Stack code supplied with the return |
| pend_valid | input | 1 | A pending exception is presented |
| pend_prio | input | 4 | Priority value of the pending exception |
| pend_fixed | input | 1 | Pending exception has fixed negative priority |
| act_ok | output | 1 | Pending exception may activate |
| sp_sel | output | 1 | Active stack: 1 = process stack |
| thread_unpriv | output | 1 | Thread privilege bit: 1 = unprivileged |

## Verification
The assertions assume the core never raises the entry and return strobes in the same cycle. They also assume the return-number, stack-code and pending-priority inputs are settled whenever their strobes or valid flag are high. The random stimulus draws at most one strobe per cycle. It alternates the mode and the privilege state often enough that unprivileged Thread phases always end through a privileged Handler write. Directed cycles cover the threshold edges, the fault-mask return with number 2, and a write that collides with a strobe.

// File: rtl/exm_pkg.sv
package exm_pkg;
  typedef enum logic [1:0] {
    SEL_BPRI = 2'd0,
    SEL_FMSK = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/exm_prio_regs.sv
module exm_prio_regs
  import exm_pkg::*;
#(
  parameter int PRIO_W  = 4,
  parameter int EXC_W   = 9,
  parameter int NMI_NUM = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  reg_sel_e          wr_sel,
  input  logic [PRIO_W-1:0] wr_prio,
  input  logic              wr_fm,
  input  logic              exc_return,
  input  logic [EXC_W-1:0]  ret_excnum,
  output logic [PRIO_W-1:0] bpri_q,
  output logic              fmask_q
);
  localparam logic [EXC_W-1:0] NMI_CODE = EXC_W'(NMI_NUM);

  logic [PRIO_W-1:0] bpri_d;
  logic              bpri_en;
  logic              fmask_d;
  logic              fmask_en;
  logic              ret_clears;

  assign ret_clears = exc_return && (ret_excnum != NMI_CODE);

  always_comb begin
    bpri_en = wr_ok && (wr_sel == SEL_BPRI);
    bpri_d  = wr_prio;
  end

  always_comb begin
    fmask_en = 1'b0;
    fmask_d  = fmask_q;
    if (ret_clears) begin
      fmask_en = 1'b1;
      fmask_d  = 1'b0;
    end else if (wr_ok && (wr_sel == SEL_FMSK)) begin
      fmask_en = 1'b1;
      fmask_d  = wr_fm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bpri_q  <= '0;
      fmask_q <= 1'b0;
    end else begin
      if (bpri_en)  bpri_q  <= bpri_d;
      if (fmask_en) fmask_q <= fmask_d;
    end
  end

  // R5: ordinary returns drop the fault mask
  a_r5_fm_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    exc_return && (ret_excnum != NMI_CODE) |=> !fmask_q);
  // R5: return from the non-maskable handler keeps it
  a_r5_fm_nmi_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    exc_return && (ret_excnum == NMI_CODE) |=> fmask_q == $past(fmask_q));
endmodule

// File: rtl/exm_ctrl_reg.sv
module exm_ctrl_reg
  import exm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_ok,
  input  reg_sel_e wr_sel,
  input  logic     wr_priv,
  input  logic     wr_stk,
  input  logic     handler_mode,
  input  logic     exc_entry,
  input  logic     exc_return,
  input  logic     ret_thread,
  input  logic     ret_psp,
  output logic     unpriv_q,
  output logic     stk_q
);
  logic ctrl_wr;
  logic unpriv_en;
  logic unpriv_d;
  logic stk_en;
  logic stk_d;

  assign ctrl_wr = wr_ok && (wr_sel == SEL_CTRL);

  always_comb begin
    unpriv_en = ctrl_wr;
    unpriv_d  = wr_priv;
  end

  always_comb begin
    stk_en = 1'b0;
    stk_d  = stk_q;
    if (exc_entry) begin
      stk_en = 1'b1;
      stk_d  = 1'b0;
    end else if (exc_return) begin
      stk_en = 1'b1;
      stk_d  = ret_thread && ret_psp;
    end else if (ctrl_wr && !handler_mode) begin
      stk_en = 1'b1;
      stk_d  = wr_stk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unpriv_q <= 1'b0;
      stk_q    <= 1'b0;
    end else begin
      if (unpriv_en) unpriv_q <= unpriv_d;
      if (stk_en)    stk_q    <= stk_d;
    end
  end

  // R7: entry selects the main stack
  a_r7_entry_main: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry |=> !stk_q);
  // R7: return restores the stack code
  a_r7_return_load: assert property (@(posedge clk) disable iff (!rst_n)
    exc_return && !exc_entry |=> stk_q == $past(ret_thread && ret_psp));
  // R6: handler-mode writes leave the stack select alone
  a_r6_handler_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    handler_mode && !exc_entry && !exc_return |=> $stable(stk_q));
endmodule

// File: rtl/exm_act_gate.sv
module exm_act_gate #(
  parameter int PRIO_W = 4
) (
  input  logic              pend_valid,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic              pend_fixed,
  input  logic [PRIO_W-1:0] bpri,
  input  logic              fmask,
  output logic              act_ok
);
  logic thr_off;
  logic thr_pass;
  logic cfg_pass;

  always_comb begin
    thr_off  = (bpri == '0);
    thr_pass = thr_off || (pend_prio < bpri);
    cfg_pass = !fmask && thr_pass;
    act_ok   = pend_valid && (pend_fixed || cfg_pass);
  end
endmodule

// File: rtl/exm_mask_ctrl.sv
module exm_mask_ctrl
  import exm_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int PRIO_W   = 4,
  parameter int PRIO_LSB = 4,
  parameter int EXC_W    = 9,
  parameter int NMI_NUM  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             handler_mode,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [XLEN-1:0]  wr_data,
  input  logic [1:0]       rd_sel,
  output logic [XLEN-1:0]  rd_data,
  input  logic             exc_entry,
  input  logic             exc_return,
  input  logic [EXC_W-1:0] ret_excnum,
  input  logic             ret_thread,
  input  logic             ret_psp,
  input  logic             pend_valid,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic             pend_fixed,
  output logic             act_ok,
  output logic             sp_sel,
  output logic             thread_unpriv
);
  localparam int PRIO_MSB = PRIO_LSB + PRIO_W - 1;

  logic              rst_meta;
  logic              rst_sync_n;
  logic              priv_now;
  logic              wr_ok;
  reg_sel_e          wsel;
  reg_sel_e          rsel;
  logic [PRIO_W-1:0] bpri_q;
  logic              fmask_q;
  logic              unpriv_q;
  logic              stk_q;
  logic [PRIO_W-1:0] wr_prio;
  logic              unused_wr_bits;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign wsel     = reg_sel_e'(wr_sel);
  assign rsel     = reg_sel_e'(rd_sel);
  assign wr_prio  = wr_data[PRIO_MSB:PRIO_LSB];
  assign priv_now = handler_mode || !unpriv_q;
  assign wr_ok    = wr_en && priv_now && !exc_entry && !exc_return;
  assign unused_wr_bits = ^{wr_data[XLEN-1:PRIO_MSB+1], wr_data[PRIO_LSB-1:2]};

  exm_prio_regs #(.PRIO_W(PRIO_W), .EXC_W(EXC_W), .NMI_NUM(NMI_NUM)) u_prio (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_ok      (wr_ok),
    .wr_sel     (wsel),
    .wr_prio    (wr_prio),
    .wr_fm      (wr_data[0]),
    .exc_return (exc_return),
    .ret_excnum (ret_excnum),
    .bpri_q     (bpri_q),
    .fmask_q    (fmask_q)
  );

  exm_ctrl_reg u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .wr_ok        (wr_ok),
    .wr_sel       (wsel),
    .wr_priv      (wr_data[0]),
    .wr_stk       (wr_data[1]),
    .handler_mode (handler_mode),
    .exc_entry    (exc_entry),
    .exc_return   (exc_return),
    .ret_thread   (ret_thread),
    .ret_psp      (ret_psp),
    .unpriv_q     (unpriv_q),
    .stk_q        (stk_q)
  );

  exm_act_gate #(.PRIO_W(PRIO_W)) u_gate (
    .pend_valid (pend_valid),
    .pend_prio  (pend_prio),
    .pend_fixed (pend_fixed),
    .bpri       (bpri_q),
    .fmask      (fmask_q),
    .act_ok     (act_ok)
  );

  assign sp_sel        = stk_q && !handler_mode;
  assign thread_unpriv = unpriv_q;

  always_comb begin
    rd_data = '0;
    case (rsel)
      SEL_BPRI: rd_data[PRIO_MSB:PRIO_LSB] = bpri_q;
      SEL_FMSK: rd_data[0] = fmask_q;
      SEL_CTRL: begin
        rd_data[0] = unpriv_q;
        rd_data[1] = sp_sel;
      end
      default:  rd_data = '0;
    endcase
  end

  // R3: at or above a live threshold nothing configurable activates
  a_r3_threshold_blocks: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pend_valid && !pend_fixed && (bpri_q != '0) && (pend_prio >= bpri_q) |-> !act_ok);
  // R4: fault mask blocks configurable, fixed always passes
  a_r4_fmask_blocks: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fmask_q && !pend_fixed |-> !act_ok);
  a_r4_fixed_passes: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pend_valid && pend_fixed |-> act_ok);
  // R6: handler mode never reports the process stack
  a_r6_handler_main: assert property (@(posedge clk) disable iff (!rst_sync_n)
    handler_mode |-> !sp_sel && !rd_data[1] || rsel != SEL_CTRL);
  // R8: unprivileged thread writes leave every register intact
  a_r8_unpriv_drop: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en && !handler_mode && unpriv_q && !exc_entry && !exc_return
      |=> $stable(bpri_q) && $stable(fmask_q) && unpriv_q);
  // R9: a strobe cycle swallows the threshold write
  a_r9_strobe_wins: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exc_entry || exc_return) |=> $stable(bpri_q));
endmodule

// File: tb/sim_exm_mask_ctrl.sv
module sim_exm_mask_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        handler_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        exc_entry = 1'b0;
  logic        exc_return = 1'b0;
  logic [8:0]  ret_excnum = '0;
  logic        ret_thread = 1'b0;
  logic        ret_psp = 1'b0;
  logic        pend_valid = 1'b0;
  logic [3:0]  pend_prio = '0;
  logic        pend_fixed = 1'b0;
  logic        act_ok;
  logic        sp_sel;
  logic        thread_unpriv;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0] m_bp = '0;
  logic       m_fm = 1'b0;
  logic       m_c0 = 1'b0;
  logic       m_c1 = 1'b0;

  always #10 clk = ~clk;

  exm_mask_ctrl u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_act(input logic pv, input logic [3:0] pp, input logic pf);
    return pv && (pf || (!m_fm && (m_bp == 4'd0 || pp < m_bp)));
  endfunction

  task automatic check_state(input string tag);
    for (int s = 0; s < 4; s++) begin
      logic [31:0] e;
      rd_sel = s[1:0];
      #1;
      case (s)
        0: e = {24'd0, m_bp, 4'd0};
        1: e = {31'd0, m_fm};
        2: e = {30'd0, m_c1 && !handler_mode, m_c0};
        default: e = '0;
      endcase
      chk(tag, rd_data, e);
    end
    chk(tag, {31'd0, sp_sel}, {31'd0, m_c1 && !handler_mode});
    chk(tag, {31'd0, thread_unpriv}, {31'd0, m_c0});
  endtask

  task automatic cyc(input string tag, input logic hm, input logic we, input logic [1:0] ws,
                     input logic [31:0] wd, input logic en, input logic rt, input logic [8:0] rn,
                     input logic rth, input logic rp, input logic pv, input logic [3:0] pp,
                     input logic pf);
    logic ok;
    @(negedge clk);
    handler_mode = hm; wr_en = we; wr_sel = ws; wr_data = wd;
    exc_entry = en; exc_return = rt; ret_excnum = rn; ret_thread = rth; ret_psp = rp;
    pend_valid = pv; pend_prio = pp; pend_fixed = pf;
    #1;
    chk(tag, {31'd0, act_ok}, {31'd0, exp_act(pv, pp, pf)});
    ok = we && (hm || !m_c0) && !en && !rt;
    @(posedge clk);
    if (rt && rn != 9'd2) m_fm = 1'b0;
    else if (ok && ws == 2'd1) m_fm = wd[0];
    if (ok && ws == 2'd0) m_bp = wd[7:4];
    if (ok && ws == 2'd2) m_c0 = wd[0];
    if (en) m_c1 = 1'b0;
    else if (rt) m_c1 = rth && rp;
    else if (ok && ws == 2'd2 && !hm) m_c1 = wd[1];
    #1;
    check_state(tag);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    check_state("R1");
    pend_valid = 1'b1; pend_prio = 4'hF; #1;
    chk("R1", {31'd0, act_ok}, 32'd1);

    // R2 threshold write and field placement
    cyc("R2", 1'b1, 1'b1, 2'd0, 32'hFFFF_FF8F, 0, 0, 0, 0, 0, 1, 4'd7, 0);
    // R3 threshold edges with value 8
    cyc("R3", 1'b1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4'd7, 0);
    cyc("R3", 1'b1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4'd8, 0);
    cyc("R3", 1'b1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4'd15, 0);
    cyc("R3", 1'b1, 1'b1, 2'd0, 32'h0, 0, 0, 0, 0, 0, 1, 4'd0, 0);
    cyc("R3", 1'b1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4'd15, 0);
    // R4 fault mask
    cyc("R4", 1'b1, 1'b1, 2'd1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 1, 4'd0, 0);
    cyc("R4", 1'b1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4'd0, 0);
    cyc("R4", 1'b1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4'd9, 1);
    cyc("R4", 1'b1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4'd0, 1);
    // R5 return from number 2 keeps, other clears
    cyc("R5", 1'b1, 0, 0, 0, 0, 1'b1, 9'd2, 0, 0, 1, 4'd3, 0);
    cyc("R5", 1'b1, 0, 0, 0, 0, 1'b1, 9'd15, 0, 0, 1, 4'd3, 0);
    // R6 handler write ignores stack bit, thread write takes it
    cyc("R6", 1'b1, 1'b1, 2'd2, 32'h3, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R6", 1'b1, 1'b1, 2'd2, 32'h2, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R6", 1'b0, 1'b1, 2'd2, 32'h2, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R6", 1'b1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R7 entry clears, return restores
    cyc("R7", 1'b0, 0, 0, 0, 1'b1, 0, 0, 0, 0, 0, 0, 0);
    cyc("R7", 1'b1, 0, 0, 0, 0, 1'b1, 9'd11, 1'b1, 1'b1, 0, 0, 0);
    cyc("R7", 1'b0, 0, 0, 0, 0, 1'b1, 9'd11, 1'b0, 1'b1, 0, 0, 0);
    // R8 unprivileged thread writes dropped
    cyc("R8", 1'b0, 1'b1, 2'd2, 32'h1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R8", 1'b0, 1'b1, 2'd0, 32'hA0, 0, 0, 0, 0, 0, 1, 4'd12, 0);
    cyc("R8", 1'b0, 1'b1, 2'd2, 32'h0, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R8", 1'b1, 1'b1, 2'd2, 32'h0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R9 strobe swallows a write
    cyc("R9", 1'b0, 1'b1, 2'd0, 32'h50, 1'b1, 0, 0, 0, 0, 1, 4'd6, 0);
    cyc("R9", 1'b1, 1'b1, 2'd1, 32'h1, 0, 1'b1, 9'd2, 1, 1, 1, 4'd6, 0);

    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] kind;
      logic en, rt;
      kind = 4'($urandom_range(0, 15));
      en = (kind == 4'd0);
      rt = (kind == 4'd1);
      cyc("R3", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
          $urandom(), en, rt, ($urandom_range(0, 3) == 0) ? 9'd2 : 9'($urandom_range(0, 511)),
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          4'($urandom_range(0, 15)), ($urandom_range(0, 7) == 0));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule